// File: doc/BRIEF.md
# Link request decoder

This block turns the serial request line driven by a link controller into decoded requests. The controller shifts one bit per clock on a line that rests at 0. A request opens with a 1, carries a 3-bit type code and the fields that type needs, and closes with a 0. All fields are sent most significant bit first. Four request kinds are understood: bus requests, register reads, register writes and arbitration-acceleration control. A bus request comes in two lengths. The short form is 7 bits and carries a 2-bit speed. The long form is 8 bits and carries a 3-bit speed. The parser tells the two apart from the bit stream alone.

Each accepted request appears for one cycle on `req_valid`, with its kind, normalised speed, address and data. Fields that a request kind does not carry read as zero. The block marks bus requests whose speed is above the fastest supported rate, so that the transmitter sends an empty packet for them. Two enable bits come in from the register file. One gates the acceleration control request. The other decides whether a bus request may change speed relative to the previous bus request when packets are concatenated.

Top module: `lreq_decoder`

## Requirements
- R1: Each request starts with a 1 on `req_in` after any number of idle 0 bits, followed by a 3-bit type sent MSB first: 001 bus request, 011 register read, 101 register write, 110 acceleration control.
- R2: A short bus request (start, type, 2-bit speed, stop 0) reports `req_speed` as the 2-bit code followed by a 0 bit. `req_valid` is seen after the clock edge that samples the bit 7 positions after the start bit.
- R3: A long bus request (start, type, 3-bit speed, stop 0) reports its 3-bit speed unchanged. `req_valid` is seen after the edge that samples its stop bit, 7 positions after the start bit.
- R4: When a short bus request is followed at once by a 1, that 1 is taken as the start bit of the next request. Both requests are decoded and no bit is lost.
- R5: `req_null` is 1 together with a bus request strobe whose speed is above 3'b100, and 0 at all other times.
- R6: A register read carries a 4-bit address and a stop bit. Its strobe follows the stop bit, 8 positions after the start, with `req_data` and `req_speed` at 0.
- R7: A register write carries a 4-bit address, then 8 data bits, then a stop bit. Its strobe follows the stop bit, 16 positions after the start.
- R8: An acceleration control request carries one bit (1 enable, 0 disable), reported on `req_data[0]` 5 positions after the start. While `eaa_en` is 0, the request is consumed with no strobe and no error.
- R9: With a bus request strobe, `concat_ok` is 1 when the speed equals that of the previous bus request (S100 after reset) or when `emc_en` is 1. Otherwise it is 0, and it is 0 whenever no bus request is strobed.
- R10: A type code outside R1 raises `req_err` for one cycle after the edge that samples the third type bit. There is no strobe, and the parser returns to idle.
- R11: A 1 where a stop bit is due ends the request with a one-cycle `req_err` and no strobe. This applies to reads, writes, acceleration requests and long bus requests whose speed ends in 1. The parser then returns to idle.
- R12: `req_valid` and `req_err` are one-cycle pulses and are never high together. Synchronous reset returns the parser to idle with every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `req_in` is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 1 | Serial request line, idles at 0 |
| eaa_en | input | 1 | Acceleration control enable from the register file |
| emc_en | input | 1 | Multispeed concatenation enable from the register file |
| req_valid | output | 1 | One-cycle strobe for a decoded request |
| req_err | output | 1 | One-cycle pulse for an unknown type or a bad stop bit |
| req_kind | output | 3 | Type code of the strobed request |
| req_speed | output | 3 | Normalised speed of a bus request |
| req_null | output | 1 | Bus request speed exceeds the supported maximum |
| req_addr | output | 4 | Register address of a read or write |
| req_data | output | 8 | Write data, or the acceleration bit in bit 0 |
| concat_ok | output | 1 | Bus request may be concatenated at this speed |

## Verification
The bench packs short bus requests directly against reads, writes, acceleration requests and other bus requests. A parser that waited for an explicit stop after the short form would drop the following start bit and misread or lose the next request. Long requests whose speed ends in 0 are also followed immediately by new requests, which would expose a parser that always treats a 1 after the speed field as the start of a new request. Speeds just above the limit and the odd long codes check the empty-packet flag. Speed changes with `emc_en` at 0 and at 1, followed by a reset, check that the speed history is kept and cleared. Unknown types and stop bits driven to 1 check that a broken frame yields a single error pulse, with no strobe, and that the parser then recovers.

// File: rtl/lreq_pkg.sv
package lreq_pkg;
    localparam int TYPE_W = 3;
    localparam int SPD_W  = 3;

    localparam logic [TYPE_W-1:0] KIND_BUS = 3'b001;
    localparam logic [TYPE_W-1:0] KIND_RD  = 3'b011;
    localparam logic [TYPE_W-1:0] KIND_WR  = 3'b101;
    localparam logic [TYPE_W-1:0] KIND_ACC = 3'b110;

    // fastest speed that can be served; anything above becomes an empty packet
    localparam logic [SPD_W-1:0] SPD_TOP = 3'b100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TYPE,
        ST_SPD,
        ST_SPD3,
        ST_AMBIG,
        ST_ADDR,
        ST_DATA,
        ST_FLAG,
        ST_STOP
    } state_e;
endpackage

// File: rtl/lreq_frame_fsm.sv
module lreq_frame_fsm
    import lreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_in,
    input  logic              eaa_en,
    output logic              o_valid,
    output logic              o_err,
    output logic [TYPE_W-1:0] o_kind,
    output logic [SPD_W-1:0]  o_speed,
    output logic [ADDR_W-1:0] o_addr,
    output logic [DATA_W-1:0] o_data
);
    localparam int MAXF  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXF + 1);

    typedef struct packed {
        state_e              st;
        logic [CNT_W-1:0]    cnt;
        logic [TYPE_W-1:0]   typ;
        logic [SPD_W-1:0]    spd;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic                o_valid;
        logic                o_err;
        logic [TYPE_W-1:0]   o_kind;
        logic [SPD_W-1:0]    o_speed;
        logic [ADDR_W-1:0]   o_addr;
        logic [DATA_W-1:0]   o_data;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.o_valid = 1'b0;
        s_d.o_err   = 1'b0;
        s_d.o_kind  = '0;
        s_d.o_speed = '0;
        s_d.o_addr  = '0;
        s_d.o_data  = '0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_in) begin
                    s_d.st  = ST_TYPE;
                    s_d.cnt = '0;
                end
            end
            ST_TYPE: begin
                s_d.typ = {s_q.typ[TYPE_W-2:0], req_in};
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == CNT_W'(TYPE_W - 1)) begin
                    s_d.cnt  = '0;
                    s_d.spd  = '0;
                    s_d.addr = '0;
                    s_d.data = '0;
                    case (s_d.typ)
                        KIND_BUS: s_d.st = ST_SPD;
                        KIND_RD:  s_d.st = ST_ADDR;
                        KIND_WR:  s_d.st = ST_ADDR;
                        KIND_ACC: s_d.st = ST_FLAG;
                        default: begin
                            s_d.st    = ST_IDLE;
                            s_d.o_err = 1'b1;
                        end
                    endcase
                end
            end
            ST_SPD: begin
                // collect the two speed bits common to both lengths
                s_d.spd = {s_q.spd[SPD_W-2:0], req_in};
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == CNT_W'(SPD_W - 2)) begin
                    s_d.st  = ST_SPD3;
                    s_d.cnt = '0;
                end
            end
            ST_SPD3: begin
                // a 1 here can only be the low speed bit of the long form
                s_d.spd = {s_q.spd[SPD_W-2:0], req_in};
                s_d.st  = req_in ? ST_STOP : ST_AMBIG;
            end
            ST_AMBIG: begin
                // 0: stop of the long form; 1: start bit of the next request
                s_d.o_valid = 1'b1;
                s_d.o_kind  = KIND_BUS;
                s_d.o_speed = s_q.spd;
                s_d.cnt     = '0;
                s_d.st      = req_in ? ST_TYPE : ST_IDLE;
            end
            ST_ADDR: begin
                s_d.addr = {s_q.addr[ADDR_W-2:0], req_in};
                s_d.cnt  = s_q.cnt + 1'b1;
                if (s_q.cnt == CNT_W'(ADDR_W - 1)) begin
                    s_d.cnt = '0;
                    s_d.st  = (s_q.typ == KIND_WR) ? ST_DATA : ST_STOP;
                end
            end
            ST_DATA: begin
                s_d.data = {s_q.data[DATA_W-2:0], req_in};
                s_d.cnt  = s_q.cnt + 1'b1;
                if (s_q.cnt == CNT_W'(DATA_W - 1)) begin
                    s_d.cnt = '0;
                    s_d.st  = ST_STOP;
                end
            end
            ST_FLAG: begin
                s_d.data = {{(DATA_W-1){1'b0}}, req_in};
                s_d.st   = ST_STOP;
            end
            ST_STOP: begin
                s_d.st = ST_IDLE;
                if (req_in) begin
                    s_d.o_err = 1'b1;
                end else begin
                    case (s_q.typ)
                        KIND_BUS: begin
                            s_d.o_valid = 1'b1;
                            s_d.o_kind  = s_q.typ;
                            s_d.o_speed = s_q.spd;
                        end
                        KIND_RD: begin
                            s_d.o_valid = 1'b1;
                            s_d.o_kind  = s_q.typ;
                            s_d.o_addr  = s_q.addr;
                        end
                        KIND_WR: begin
                            s_d.o_valid = 1'b1;
                            s_d.o_kind  = s_q.typ;
                            s_d.o_addr  = s_q.addr;
                            s_d.o_data  = s_q.data;
                        end
                        KIND_ACC: begin
                            if (eaa_en) begin
                                s_d.o_valid = 1'b1;
                                s_d.o_kind  = s_q.typ;
                                s_d.o_data  = s_q.data;
                            end
                        end
                        default: s_d.o_err = 1'b1;
                    endcase
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign o_valid = s_q.o_valid;
    assign o_err   = s_q.o_err;
    assign o_kind  = s_q.o_kind;
    assign o_speed = s_q.o_speed;
    assign o_addr  = s_q.o_addr;
    assign o_data  = s_q.o_data;

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({o_valid, o_err}));
    assert_strobe_single_R12: assert property (@(posedge clk) disable iff (rst)
        o_valid |=> !o_valid);
    assert_err_single_R10: assert property (@(posedge clk) disable iff (rst)
        o_err |=> !o_err);
    assert_read_no_data_R6: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_kind == KIND_RD) |-> (o_data == '0 && o_speed == '0));
    assert_accel_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_kind == KIND_ACC) |-> $past(eaa_en));
endmodule

// File: rtl/lreq_speed_check.sv
module lreq_speed_check
    import lreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic [SPD_W-1:0] speed,
    output logic             null_pkt
);
    always_comb begin
        null_pkt = bus_valid && (speed > SPD_TOP);
    end

    assert_null_bus_only_R5: assert property (@(posedge clk) disable iff (rst)
        null_pkt |-> bus_valid);
endmodule

// File: rtl/lreq_concat_track.sv
module lreq_concat_track
    import lreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic [SPD_W-1:0] speed,
    input  logic             emc_en,
    output logic             concat_ok
);
    logic [SPD_W-1:0] last_d, last_q;

    always_comb begin
        last_d    = last_q;
        concat_ok = 1'b0;
        if (bus_valid) begin
            concat_ok = (speed == last_q) || emc_en;
            last_d    = speed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= last_d;
    end

    assert_concat_bus_only_R9: assert property (@(posedge clk) disable iff (rst)
        concat_ok |-> bus_valid);
    assert_concat_emc_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && emc_en) |-> concat_ok);
endmodule

// File: rtl/lreq_decoder.sv
module lreq_decoder
    import lreq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_in,
    input  logic              eaa_en,
    input  logic              emc_en,
    output logic              req_valid,
    output logic              req_err,
    output logic [TYPE_W-1:0] req_kind,
    output logic [SPD_W-1:0]  req_speed,
    output logic              req_null,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              concat_ok
);
    logic bus_valid;

    lreq_frame_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req_in  (req_in),
        .eaa_en  (eaa_en),
        .o_valid (req_valid),
        .o_err   (req_err),
        .o_kind  (req_kind),
        .o_speed (req_speed),
        .o_addr  (req_addr),
        .o_data  (req_data)
    );

    assign bus_valid = req_valid && (req_kind == KIND_BUS);

    lreq_speed_check u_spd (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .speed     (req_speed),
        .null_pkt  (req_null)
    );

    lreq_concat_track u_cat (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .speed     (req_speed),
        .emc_en    (emc_en),
        .concat_ok (concat_ok)
    );
endmodule

// File: tb/lreq_decoder_tb.sv
module lreq_decoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_in = 1'b0;
    logic       eaa_en = 1'b1;
    logic       emc_en = 1'b0;
    logic       req_valid, req_err, req_null, concat_ok;
    logic [2:0] req_kind, req_speed;
    logic [3:0] req_addr;
    logic [7:0] req_data;

    always #10 clk = ~clk;

    lreq_decoder u_dut (
        .clk(clk), .rst(rst), .req_in(req_in), .eaa_en(eaa_en), .emc_en(emc_en),
        .req_valid(req_valid), .req_err(req_err), .req_kind(req_kind),
        .req_speed(req_speed), .req_null(req_null), .req_addr(req_addr),
        .req_data(req_data), .concat_ok(concat_ok)
    );

    typedef struct {
        int         idx;
        int         mode;   // 0 strobe, 1 error, 2 nothing expected
        logic [2:0] kind;
        logic [2:0] spd;
        logic [3:0] addr;
        logic [7:0] data;
        string      tag;
    } ev_t;

    ev_t  evq[$];
    logic bit_s[$];
    logic eaa_s[$];
    logic emc_s[$];
    logic cur_eaa = 1'b1;
    logic cur_emc = 1'b0;
    logic [2:0] last_spd = 3'b000;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push_bits(logic [16:0] v, int w);
        for (int k = w - 1; k >= 0; k--) begin
            bit_s.push_back(v[k]);
            eaa_s.push_back(cur_eaa);
            emc_s.push_back(cur_emc);
        end
    endtask

    task automatic add_ev(int idx, int mode, logic [2:0] kind, logic [2:0] spd,
                          logic [3:0] addr, logic [7:0] data, string tag);
        ev_t e;
        e.idx = idx; e.mode = mode; e.kind = kind; e.spd = spd;
        e.addr = addr; e.data = data; e.tag = tag;
        evq.push_back(e);
    endtask

    task automatic idle(int n);
        push_bits(17'd0, n);
    endtask

    task automatic bus_short(logic [1:0] c, string tag);
        int st = bit_s.size();
        push_bits({10'd0, 1'b1, 3'b001, c, 1'b0}, 7);
        add_ev(st + 7, 0, 3'b001, {c, 1'b0}, 4'h0, 8'h00, tag);
    endtask

    task automatic bus_long(logic [2:0] c, string tag);
        int st = bit_s.size();
        push_bits({9'd0, 1'b1, 3'b001, c, 1'b0}, 8);
        add_ev(st + 7, 0, 3'b001, c, 4'h0, 8'h00, tag);
    endtask

    task automatic reg_read(logic [3:0] a, string tag);
        int st = bit_s.size();
        push_bits({8'd0, 1'b1, 3'b011, a, 1'b0}, 9);
        add_ev(st + 8, 0, 3'b011, 3'b000, a, 8'h00, tag);
    endtask

    task automatic reg_write(logic [3:0] a, logic [7:0] d, string tag);
        int st = bit_s.size();
        push_bits({1'b1, 3'b101, a, d, 1'b0}, 17);
        add_ev(st + 16, 0, 3'b101, 3'b000, a, d, tag);
    endtask

    task automatic accel(logic e);
        int st = bit_s.size();
        push_bits({11'd0, 1'b1, 3'b110, e, 1'b0}, 6);
        if (cur_eaa) add_ev(st + 5, 0, 3'b110, 3'b000, 4'h0, {7'd0, e}, "R8");
        else         add_ev(st + 5, 2, 3'b000, 3'b000, 4'h0, 8'h00, "R8");
    endtask

    task automatic bad_type(logic [2:0] t);
        int st = bit_s.size();
        push_bits({13'd0, 1'b1, t}, 4);
        add_ev(st + 3, 1, 3'b000, 3'b000, 4'h0, 8'h00, "R10");
        idle(3);
    endtask

    task automatic bad_stop_read(logic [3:0] a);
        int st = bit_s.size();
        push_bits({8'd0, 1'b1, 3'b011, a, 1'b1}, 9);
        add_ev(st + 8, 1, 3'b000, 3'b000, 4'h0, 8'h00, "R11");
        idle(2);
    endtask

    task automatic bad_stop_long(logic [2:0] c);
        int st = bit_s.size();
        push_bits({9'd0, 1'b1, 3'b001, c, 1'b1}, 8);
        add_ev(st + 7, 1, 3'b000, 3'b000, 4'h0, 8'h00, "R11");
        idle(2);
    endtask

    task automatic check_idx(int idx);
        ev_t e;
        bit  have;
        logic exp_null, exp_cc;
        have = (evq.size() > 0) && (evq[0].idx == idx);
        if (have) e = evq.pop_front();
        if (have && e.mode == 0) begin
            exp_null = (e.kind == 3'b001) && (e.spd > 3'b100);
            exp_cc   = (e.kind == 3'b001) && ((e.spd == last_spd) || emc_en);
            chk(req_valid === 1'b1 && req_err === 1'b0, e.tag, "strobe",
                {req_valid, req_err}, 2'b10);
            chk(req_kind === e.kind, e.tag, "kind", req_kind, e.kind);
            chk(req_speed === e.spd, e.tag, "speed", req_speed, e.spd);
            chk(req_addr === e.addr, e.tag, "addr", req_addr, e.addr);
            chk(req_data === e.data, e.tag, "data", req_data, e.data);
            chk(req_null === exp_null, "R5", "null", req_null, exp_null);
            chk(concat_ok === exp_cc, "R9", "concat", concat_ok, exp_cc);
            if (e.kind == 3'b001) last_spd = e.spd;
        end else if (have && e.mode == 1) begin
            chk(req_err === 1'b1 && req_valid === 1'b0, e.tag, "error pulse",
                {req_valid, req_err}, 2'b01);
        end else begin
            chk(req_valid === 1'b0 && req_err === 1'b0 && req_null === 1'b0 &&
                concat_ok === 1'b0, have ? e.tag : "R12", "quiet",
                {req_valid, req_err, req_null, concat_ok}, 0);
        end
    endtask

    task automatic run_stream();
        int n = bit_s.size() + 4;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) check_idx(i - 1);
            if (i < bit_s.size()) begin
                req_in = bit_s[i];
                eaa_en = eaa_s[i];
                emc_en = emc_s[i];
            end else begin
                req_in = 1'b0;
            end
        end
        chk(evq.size() == 0, "R12", "events left", evq.size(), 0);
        evq.delete();
        bit_s.delete();
        eaa_s.delete();
        emc_s.delete();
    endtask

    task automatic check_reset_state(string what);
        chk(req_valid === 1'b0 && req_err === 1'b0 && req_null === 1'b0 &&
            concat_ok === 1'b0 && req_kind === 3'd0 && req_speed === 3'd0 &&
            req_addr === 4'd0 && req_data === 8'd0, "R12", what,
            {req_valid, req_err, req_kind, req_speed, req_addr, req_data}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("reset outputs");
        rst = 1'b0;

        idle(3);
        bus_short(2'b00, "R4");          // short form packed against a read
        reg_read(4'hA, "R4");
        idle(2);
        bus_long(3'b010, "R3");          // long form, next request at once
        bus_short(2'b10, "R2");
        bus_short(2'b10, "R4");
        reg_write(4'h5, 8'hC3, "R7");
        idle(1);
        bus_long(3'b101, "R5");
        bus_long(3'b111, "R5");
        bus_short(2'b11, "R5");
        idle(2);
        cur_emc = 1'b1;
        bus_short(2'b01, "R9");
        bus_long(3'b100, "R9");
        idle(1);
        accel(1'b1);
        accel(1'b0);
        cur_eaa = 1'b0;
        accel(1'b1);
        bus_short(2'b00, "R4");          // short form packed against an ignored accel
        accel(1'b1);
        cur_eaa = 1'b1;
        cur_emc = 1'b0;
        idle(2);
        bad_type(3'b010);
        bad_type(3'b111);
        bad_type(3'b000);
        bad_stop_read(4'h3);
        bad_stop_long(3'b011);
        bus_short(2'b01, "R4");
        reg_write(4'hF, 8'h5A, "R4");
        bus_long(3'b000, "R3");
        reg_read(4'h0, "R6");
        bus_long(3'b010, "R1");
        idle(2);
        run_stream();

        // reset in the middle of a write frame
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            req_in = (k == 0 || k == 1 || k == 3 || k == 4);
        end
        @(negedge clk);
        rst = 1'b1;
        req_in = 1'b0;
        repeat (2) @(negedge clk);
        check_reset_state("mid-frame reset");
        rst = 1'b0;
        last_spd = 3'b000;

        idle(2);
        bus_long(3'b000, "R9");          // speed history cleared by reset
        reg_read(4'h9, "R12");
        run_stream();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule